// File: doc/BRIEF.md
# Misaligned Access Lane Steering Unit

This unit sits between a processor's load/store port and a set of 32-bit-wide memory windows. On the request side it maps the processor address to a word-aligned memory address and byte enables, and replicates write data across the lanes. It also flags writes that the target window must discard. On the return side it rotates or extracts the raw word according to the access size and the low address bits. It then registers the result for the processor.

A few windows need special lane handling, and each window is identified by address bits [31:24]. The boot-ROM window (0x00) returns a latched prefetch word when the processor is not executing from it. The I/O window (0x04) serves byte reads from the aligned halfword. The video RAM window (0x06) widens or discards byte writes and folds its upper mirror. The object attribute window (0x07) refuses byte writes. The memories, the wait timing and any wider decoding are outside the unit.

The access size is encoded as 0 for byte, 1 for halfword and 2 for word. Code 3 is treated as a word. The window offset is address bits [23:0].

Top module: `lane_steer`

## Requirements
- R1: A word read returns the aligned raw word rotated right by 8 × addr[1:0] bits.
- R2: A halfword read takes the raw halfword selected by addr[1] (1 = bits 31:16). When addr[0] is 1, that halfword is rotated right by 8 bits. The result is zero-extended to 32 bits.
- R3: A byte read returns raw byte lane addr[1:0], zero-extended. A byte read in the I/O window drives both byte enables of the aligned halfword (lanes 1:0 or 3:2 by addr[1]). For any other byte read or non-video byte write, mem_be is one-hot at bit addr[1:0].
- R4: For a read in the boot-ROM window while pc_in_boot is 0, the word most recently captured through pf_load replaces the raw data before the rules of R1–R3 are applied. While pc_in_boot is 1, the raw data is used.
- R5: Word writes (size 2 or 3) enable all four lanes with the data unchanged. Halfword writes enable lanes 1:0 (addr[1]=0) or 3:2 (addr[1]=1), with the halfword duplicated in both halves of mem_wdata. Byte writes replicate the byte into all four lanes of mem_wdata.
- R6: A byte write to video RAM at an offset below 0x18000 enables both lanes of the aligned halfword, so the byte lands in both of its bytes.
- R7: A byte write to video RAM at an offset of 0x18000 or above, and any byte write to the object attribute window, raise mem_drop with mem_be all zero.
- R8: For halfword and word writes to video RAM, offsets below 0x18000 are kept as they are. Offsets from 0x18000 up to 0x1FFFF are masked with 0x17FFF. Offsets of 0x20000 and above are dropped, with mem_drop high and mem_be zero.
- R9: mem_addr always has bits [1:0] clear and keeps bits [31:24]. Video RAM reads mask their offset with 0x1FFFF. All other accesses pass the offset through unchanged.
- R10: rd_valid is high in exactly the cycle after a cycle with rsp_valid high, and rd_data holds its value otherwise. After reset, rd_valid and rd_data are 0. With req_valid low, mem_be is 0 and mem_drop is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_addr | input | 32 | Processor byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_write | input | 1 | 1 for a store |
| req_wdata | input | 32 | Store data, right-justified |
| pc_in_boot | input | 1 | Program counter lies in the boot-ROM window |
| pf_load | input | 1 | Capture pf_word as the boot prefetch value |
| pf_word | input | 32 | Prefetch word to capture |
| mem_addr | output | 32 | Word-aligned, window-mapped memory address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_drop | output | 1 | Store must be discarded |
| rsp_valid | input | 1 | Raw read word valid from the window |
| rsp_raw | input | 32 | Raw aligned read word |
| rd_valid | output | 1 | Steered read result valid |
| rd_data | output | 32 | Rotated / extracted read result |

## Verification
The bench targets the lane boundaries where a wrong design fails quietly. It checks word reads at each of the three misaligned offsets, where an unrotated design returns the raw word. It checks halfword reads with bit 0 set, which come back unswapped from a design that ignores that bit. It checks I/O byte reads that enable only one lane when they should enable the halfword. The video RAM offsets just either side of 0x18000 and 0x20000 are driven on purpose. A design with an off-by-one compare there would write object memory from a byte store or leave the mirror unfolded. The bench also toggles pc_in_boot and reloads the prefetch latch, so a design that substitutes the wrong word, or substitutes inside the boot window, returns the wrong data.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        WIN_BOOT,
        WIN_IO,
        WIN_VRAM,
        WIN_OAM,
        WIN_OTHER
    } win_e;

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        acc_size_e         size;
        logic              swap;
    } rd_ctx_t;

    function automatic logic [DATA_W-1:0] rotr_lanes(input logic [DATA_W-1:0] x,
                                                     input logic [LANE_W-1:0] n);
        logic [2*DATA_W-1:0] dbl;
        dbl = {x, x} >> (n * 8);
        return dbl[DATA_W-1:0];
    endfunction

    function automatic logic [LANES-1:0] half_lanes(input logic upper);
        return upper ? 4'b1100 : 4'b0011;
    endfunction

endpackage

// File: rtl/lane_win_decode.sv
module lane_win_decode
    import lane_pkg::*;
#(
    parameter int         ADDR_W  = 32,
    parameter logic [7:0] BOOT_ID = 8'h00,
    parameter logic [7:0] IO_ID   = 8'h04,
    parameter logic [7:0] VRAM_ID = 8'h06,
    parameter logic [7:0] OAM_ID  = 8'h07
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win
);
    logic [7:0] id;
    assign id = addr[ADDR_W-1 -: 8];

    always_comb begin
        if (id == BOOT_ID)      win = WIN_BOOT;
        else if (id == IO_ID)   win = WIN_IO;
        else if (id == VRAM_ID) win = WIN_VRAM;
        else if (id == OAM_ID)  win = WIN_OAM;
        else                    win = WIN_OTHER;
    end
endmodule

// File: rtl/lane_req_steer.sv
module lane_req_steer
    import lane_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 24,
    parameter int VRAM_BYTES = 32'h18000,
    parameter int VRAM_SPAN  = 32'h20000,
    parameter int VRAM_OBJ   = 32'h18000
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  acc_size_e         req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  win_e              win,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_drop
);
    localparam logic [OFF_W-1:0] SPAN_MASK = OFF_W'(VRAM_SPAN - 1);
    localparam logic [OFF_W-1:0] FOLD_MASK = OFF_W'((VRAM_SPAN - 1) & ~(VRAM_SPAN - VRAM_BYTES));
    localparam logic [OFF_W-1:0] LIM_SIZE  = OFF_W'(VRAM_BYTES);
    localparam logic [OFF_W-1:0] LIM_SPAN  = OFF_W'(VRAM_SPAN);
    localparam logic [OFF_W-1:0] LIM_OBJ   = OFF_W'(VRAM_OBJ);

    logic [OFF_W-1:0]  off, off_m;
    logic [LANE_W-1:0] lane;
    logic [LANES-1:0]  be;
    logic              drop;

    assign off  = req_addr[OFF_W-1:0];
    assign lane = req_addr[LANE_W-1:0];

    always_comb begin
        off_m     = off;
        be        = '0;
        drop      = 1'b0;
        mem_wdata = req_wdata;

        if (win == WIN_VRAM) begin
            if (req_write && req_size != SZ_BYTE) begin
                if (off < LIM_SIZE)      off_m = off & SPAN_MASK;
                else if (off < LIM_SPAN) off_m = off & FOLD_MASK;
                else                     drop  = 1'b1;
            end else begin
                off_m = off & SPAN_MASK;
            end
        end

        unique case (req_size)
            SZ_BYTE: begin
                mem_wdata = {LANES{req_wdata[7:0]}};
                be        = LANES'(1) << lane;
                if (win == WIN_IO && !req_write)
                    be = half_lanes(lane[1]);
                if (req_write && win == WIN_VRAM) begin
                    if (off >= LIM_OBJ) drop = 1'b1;
                    else                be   = half_lanes(lane[1]);
                end
                if (req_write && win == WIN_OAM)
                    drop = 1'b1;
            end
            SZ_HALF: begin
                mem_wdata = {2{req_wdata[15:0]}};
                be        = half_lanes(lane[1]);
            end
            default: be = '1;
        endcase

        mem_drop = req_valid & drop;
        mem_be   = (req_valid && !drop) ? be : '0;
        mem_addr = {req_addr[ADDR_W-1:OFF_W], off_m[OFF_W-1:LANE_W], {LANE_W{1'b0}}};
    end
endmodule

// File: rtl/lane_rd_align.sv
module lane_rd_align
    import lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  rd_ctx_t           cap_ctx,
    input  logic              pf_load,
    input  logic [DATA_W-1:0] pf_word,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_raw,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    rd_ctx_t           ctx_q;
    logic [DATA_W-1:0] pf_q;
    logic [DATA_W-1:0] src, res;
    logic [15:0]       hw;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
            pf_q  <= '0;
        end else begin
            if (cap_en)  ctx_q <= cap_ctx;
            if (pf_load) pf_q  <= pf_word;
        end
    end

    always_comb begin
        src = ctx_q.swap ? pf_q : rsp_raw;
        hw  = ctx_q.lane[1] ? src[31:16] : src[15:0];
        if (ctx_q.lane[0]) hw = {hw[7:0], hw[15:8]};
        unique case (ctx_q.size)
            SZ_BYTE: res = {{(DATA_W-8){1'b0}}, src[ctx_q.lane*8 +: 8]};
            SZ_HALF: res = {{(DATA_W-16){1'b0}}, hw};
            default: res = rotr_lanes(src, ctx_q.lane);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rsp_valid;
            if (rsp_valid) rd_data <= res;
        end
    end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import lane_pkg::*;
#(
    parameter int         ADDR_W     = 32,
    parameter int         OFF_W      = 24,
    parameter logic [7:0] BOOT_ID    = 8'h00,
    parameter logic [7:0] IO_ID      = 8'h04,
    parameter logic [7:0] VRAM_ID    = 8'h06,
    parameter logic [7:0] OAM_ID     = 8'h07,
    parameter int         VRAM_BYTES = 32'h18000,
    parameter int         VRAM_SPAN  = 32'h20000,
    parameter int         VRAM_OBJ   = 32'h18000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    input  logic              pc_in_boot,
    input  logic              pf_load,
    input  logic [31:0]       pf_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic              mem_drop,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_raw,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);
    win_e      win;
    acc_size_e size;
    rd_ctx_t   ctx;

    assign size = acc_size_e'(req_size);

    lane_win_decode #(
        .ADDR_W(ADDR_W), .BOOT_ID(BOOT_ID), .IO_ID(IO_ID),
        .VRAM_ID(VRAM_ID), .OAM_ID(OAM_ID)
    ) u_dec (
        .addr(req_addr),
        .win (win)
    );

    lane_req_steer #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .VRAM_BYTES(VRAM_BYTES),
        .VRAM_SPAN(VRAM_SPAN), .VRAM_OBJ(VRAM_OBJ)
    ) u_req (
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_size (size),
        .req_write(req_write),
        .req_wdata(req_wdata),
        .win      (win),
        .mem_addr (mem_addr),
        .mem_be   (mem_be),
        .mem_wdata(mem_wdata),
        .mem_drop (mem_drop)
    );

    assign ctx.lane = req_addr[LANE_W-1:0];
    assign ctx.size = size;
    assign ctx.swap = (win == WIN_BOOT) && !pc_in_boot;

    lane_rd_align u_rd (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (req_valid && !req_write),
        .cap_ctx  (ctx),
        .pf_load  (pf_load),
        .pf_word  (pf_word),
        .rsp_valid(rsp_valid),
        .rsp_raw  (rsp_raw),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic [1:0]  req_size,
    input logic        req_write,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic        mem_drop,
    input logic        rsp_valid,
    input logic        rd_valid,
    input logic [31:0] rd_data
);
    p_drop_no_lanes_r7: assert property (@(posedge clk) disable iff (rst)
        mem_drop |-> mem_be == 4'h0);

    p_obj_byte_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size == 2'd0 && req_addr[31:24] == 8'h06
         && req_addr[23:0] >= 24'h018000) |-> mem_drop);

    p_addr_aligned_r9: assert property (@(posedge clk) disable iff (rst)
        mem_addr[1:0] == 2'b00);

    p_word_write_lanes_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size[1] && !mem_drop) |-> mem_be == 4'hF);

    p_rsp_to_valid_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> rd_valid);

    p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |=> !rd_valid);

    p_hold_data_r10: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |=> $stable(rd_data));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (mem_be == 4'h0 && !mem_drop));
endmodule

bind lane_steer lane_steer_chk u_chk (.*);

// File: tb/test_lane_steer.sv
module test_lane_steer;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, pc_in_boot, pf_load, rsp_valid;
    logic [31:0] req_addr, req_wdata, pf_word, rsp_raw;
    logic [1:0]  req_size;
    logic [31:0] mem_addr, mem_wdata, rd_data;
    logic [3:0]  mem_be;
    logic        mem_drop, rd_valid;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] pf_model = 32'h0;

    always #10 clk = ~clk;

    lane_steer i_lane_steer (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h addr=%08h size=%0d wr=%0b",
                     req, act, exp, req_addr, req_size, req_write);
        end
    endtask

    function automatic logic e_drop(input logic [31:0] a, input logic [1:0] sz, input logic wr);
        logic [7:0]  id  = a[31:24];
        logic [23:0] off = a[23:0];
        if (!wr) return 1'b0;
        if (id == 8'h07 && sz == 2'd0) return 1'b1;
        if (id == 8'h06 && sz == 2'd0 && off >= 24'h018000) return 1'b1;
        if (id == 8'h06 && sz != 2'd0 && off >= 24'h020000) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] e_addr(input logic [31:0] a, input logic [1:0] sz, input logic wr);
        logic [23:0] off = a[23:0];
        if (a[31:24] == 8'h06) begin
            if (wr && sz != 2'd0 && off >= 24'h018000 && off < 24'h020000)
                off = off - 24'h008000;
            else
                off = off % 24'h020000;
        end
        return {a[31:24], off[23:2], 2'b00};
    endfunction

    function automatic logic [3:0] e_be(input logic [31:0] a, input logic [1:0] sz, input logic wr);
        if (e_drop(a, sz, wr)) return 4'h0;
        if (sz >= 2'd2) return 4'hF;
        if (sz == 2'd1) return a[1] ? 4'hC : 4'h3;
        if ((a[31:24] == 8'h04 && !wr) || (a[31:24] == 8'h06 && wr))
            return a[1] ? 4'hC : 4'h3;
        return 4'h1 << a[1:0];
    endfunction

    function automatic logic [31:0] e_wd(input logic [31:0] d, input logic [1:0] sz);
        if (sz == 2'd0) return {d[7:0], d[7:0], d[7:0], d[7:0]};
        if (sz == 2'd1) return {d[15:0], d[15:0]};
        return d;
    endfunction

    function automatic logic [31:0] e_rd(input logic [31:0] raw, input logic [31:0] a, input logic [1:0] sz);
        logic [63:0] w;
        logic [15:0] h;
        if (sz >= 2'd2) begin
            w = {raw, raw} >> (8 * a[1:0]);
            return w[31:0];
        end
        if (sz == 2'd1) begin
            h = a[1] ? raw[31:16] : raw[15:0];
            if (a[0]) h = {h[7:0], h[15:8]};
            return {16'h0, h};
        end
        return (raw >> (8 * a[1:0])) & 32'hFF;
    endfunction

    task automatic load_pf(input logic [31:0] v);
        @(negedge clk);
        pf_load = 1'b1; pf_word = v;
        @(negedge clk);
        pf_load = 1'b0;
        pf_model = v;
    endtask

    task automatic txn(input string tag, input logic [31:0] a, input logic [1:0] sz,
                       input logic wr, input logic [31:0] d, input logic pcb,
                       input logic [31:0] raw);
        logic [31:0] src, exp;
        logic        dr;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
        req_wdata = d; pc_in_boot = pcb; rsp_valid = 1'b0;
        #2;
        dr = e_drop(a, sz, wr);
        chk({tag, " drop"}, {31'h0, mem_drop}, {31'h0, dr});
        chk({tag, " be"}, {28'h0, mem_be}, {28'h0, e_be(a, sz, wr)});
        if (!dr) chk({tag, " addr"}, mem_addr, e_addr(a, sz, wr));
        if (wr && !dr) chk({tag, " wdata"}, mem_wdata, e_wd(d, sz));
        chk("R10 no valid without response", {31'h0, rd_valid}, 32'h0);
        if (!wr) begin
            src = (a[31:24] == 8'h00 && !pcb) ? pf_model : raw;
            exp = e_rd(src, a, sz);
            @(negedge clk);
            req_valid = 1'b0; rsp_valid = 1'b1; rsp_raw = raw;
            @(negedge clk);
            rsp_valid = 1'b0;
            chk("R10 valid after response", {31'h0, rd_valid}, 32'h1);
            chk({tag, " rdata"}, rd_data, exp);
            @(negedge clk);
            chk("R10 data held", rd_data, exp);
        end else begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] ids [6] = '{8'h00, 8'h04, 8'h06, 8'h07, 8'h02, 8'h08};
        void'($urandom(32'h5EED1234));
        rst = 1'b1; req_valid = 0; req_addr = 0; req_size = 0; req_write = 0;
        req_wdata = 0; pc_in_boot = 1; pf_load = 0; pf_word = 0;
        rsp_valid = 0; rsp_raw = 0;
        repeat (3) @(negedge clk);
        chk("R10 reset valid", {31'h0, rd_valid}, 32'h0);
        chk("R10 reset data", rd_data, 32'h0);
        chk("R10 idle be", {28'h0, mem_be}, 32'h0);
        rst = 1'b0;

        // R1 word rotation at each offset
        for (int i = 0; i < 4; i++)
            txn("R1", 32'h0300_0100 + i, 2'd2, 0, 0, 1, 32'h4433_2211);
        txn("R1 reserved size", 32'h0300_0203, 2'd3, 0, 0, 1, 32'hA1B2_C3D4);
        // R2 halfword lanes and odd swap
        for (int i = 0; i < 4; i++)
            txn("R2", 32'h0200_0040 + i, 2'd1, 0, 0, 1, 32'hDEAD_BEEF);
        // R3 byte reads, I/O window halfword enables
        txn("R3", 32'h0200_0013, 2'd0, 0, 0, 1, 32'h8877_6655);
        txn("R3 io upper", 32'h0400_0005, 2'd0, 0, 0, 1, 32'h1234_5678);
        txn("R3 io lower", 32'h0400_0006, 2'd0, 0, 0, 1, 32'h1234_5678);
        // R4 boot substitution
        load_pf(32'hCAFE_F00D);
        txn("R4 outside", 32'h0000_0102, 2'd2, 0, 0, 0, 32'h0BAD_0BAD);
        txn("R4 inside", 32'h0000_0102, 2'd2, 0, 0, 1, 32'h0BAD_0BAD);
        txn("R4 outside half", 32'h0000_0003, 2'd1, 0, 0, 0, 32'h0BAD_0BAD);
        // R5 writes
        txn("R5 word", 32'h0300_0007, 2'd2, 1, 32'h1122_3344, 1, 0);
        txn("R5 half", 32'h0200_0002, 2'd1, 1, 32'h0000_ABCD, 1, 0);
        txn("R5 byte", 32'h0200_0003, 2'd0, 1, 32'h0000_00EE, 1, 0);
        // R6 / R7 video byte writes
        txn("R6 below obj", 32'h0601_7FFF, 2'd0, 1, 32'h5A, 1, 0);
        txn("R7 obj edge", 32'h0601_8000, 2'd0, 1, 32'h5A, 1, 0);
        txn("R7 oam byte", 32'h0700_0010, 2'd0, 1, 32'h5A, 1, 0);
        txn("R7 oam half ok", 32'h0700_0010, 2'd1, 1, 32'h5A5A, 1, 0);
        // R8 video folding
        txn("R8 keep", 32'h0601_7FFE, 2'd1, 1, 32'h1111, 1, 0);
        txn("R8 fold", 32'h0601_A002, 2'd1, 1, 32'h2222, 1, 0);
        txn("R8 fold top", 32'h0601_FFFC, 2'd2, 1, 32'h3333_4444, 1, 0);
        txn("R8 drop", 32'h0602_0004, 2'd2, 1, 32'h5555, 1, 0);
        // R9 video read masking
        txn("R9 read mask", 32'h0602_1000, 2'd2, 0, 0, 1, 32'h7777_8888);

        for (int n = 0; n < 3000; n++) begin
            logic [7:0]  id  = ids[$urandom % 6];
            logic [23:0] off = (id == 8'h06) ? 24'($urandom % 32'h30000) : 24'($urandom);
            if (n % 97 == 0) load_pf($urandom);
            txn("R1-R9 random", {id, off}, 2'($urandom), 1'($urandom),
                $urandom, 1'($urandom), $urandom);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule